// File: doc/BRIEF.md
# Programmable Delay Line and Circular Buffer

This block is a 10-bit data pipeline whose length is set at run time. A word enters through an input register, passes through a RAM-backed delay section, and leaves through an output register. The total latency is the programmed length value plus the two fixed registers, so it ranges from 2 to 1281 active clock edges. The length is written into a length register with a load strobe. A mode input can close the loop so that the output word goes back into the input register. The same storage then acts as a circular buffer that replays the words it holds.

The active clock edge can be either edge of the system clock, chosen by a select input. A clock enable freezes every piece of state. An output enable either presents the output word or marks the output as not driven; the not-driven state stands in for a high-impedance bus driver. The RAM section uses one circular address. At each active edge it reads the oldest word and writes the newest word at the same location. A programmed value of zero bypasses the RAM.

Top module: `prog_delay_line`

## Requirements
- R1: After an asynchronous reset (rstN low), the output word is 0, the programmed length is 0, and with outEn high doutDriven is 1.
- R2: In delay mode (recircMode = 0) with programmed value N between 0 and 1279, a word sampled from din at active edge k appears on dout right after active edge k+N+1. The total latency is therefore N+2 active edges.
- R3: With N = 0 the RAM is bypassed, and dout after active edge k+1 equals din sampled at edge k.
- R4: When lenLoad is high at an enabled active edge, lenIn is captured as the new length and the RAM address restarts at 0. Words sampled from that edge onward come out with the new latency.
- R5: A lenIn value above 1279 is stored as 1279, which gives a latency of 1281 edges.
- R6: In recirculate mode (recircMode = 1), din is ignored and the input register takes the current output word. dout then repeats with a period of N+2 active edges.
- R7: While clkEn is low, no state changes. dout holds, and din and lenLoad have no effect. When clkEn returns high, the latency is unchanged.
- R8: With fallEdge = 1, all state updates on the falling edge of clk and none on the rising edge. With fallEdge = 0 the rising edge is active. fallEdge is changed only while reset is held.
- R9: While outEn is low, dout reads 0 and doutDriven is 0. The pipeline keeps running, and once outEn is high again dout matches the delayed input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fallEdge | input | 1 | 1 selects the falling edge of clk as active |
| clkEn | input | 1 | Clock enable; low holds all state |
| lenLoad | input | 1 | Load strobe for the length register |
| lenIn | input | 11 | Programmed length (total latency minus 2) |
| recircMode | input | 1 | 0 = delay mode, 1 = recirculate mode |
| din | input | 10 | Input data word |
| outEn | input | 1 | Output enable |
| dout | output | 10 | Output data word, 0 when not driven |
| doutDriven | output | 1 | 1 when dout is driven, 0 for the high-impedance state |

## Verification
Each output word is due exactly N+1 active edges after the edge that sampled it. Disabled edges are not counted. After a length load, the first correct word is the one sampled at the load edge itself. The bench keeps a history of each word the input register takes: din in delay mode, the previous dout in recirculate mode. After every active edge it compares dout with the entry N+2 positions back, but only once N+2 enabled edges have passed since the last load. The effects of clock enable, output enable and edge select are checked two nanoseconds after the relevant edge. For edge select, the bench also checks that nothing moves on the inactive edge.

// File: rtl/pdl_pkg.sv
package pdl_pkg;
  // Strobes sent from the control section to the datapath.
  typedef struct packed {
    logic advance;   // enabled active edge: registers move
    logic ramWrite;  // write the input register into the RAM this edge
    logic bypass;    // programmed length is zero: skip the RAM
    logic recirc;    // input register takes the output register
  } pdlCtl_t;
endpackage

// File: rtl/pdl_ctrl.sv
module pdl_ctrl
  import pdl_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int MAX_PROG = 1279,
  parameter int ADDR_W   = 11
) (
  input  logic              clkInt,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              lenLoad,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              recircMode,
  output pdlCtl_t           ctl,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [LEN_W-1:0]  lenQ
);
  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_PROG);

  logic [LEN_W-1:0]  lenClamped;
  logic [ADDR_W-1:0] ptrQ;
  logic [ADDR_W-1:0] lastAddr;
  logic              lenZero;

  assign lenClamped = (lenIn > LEN_CAP) ? LEN_CAP : lenIn;
  assign lenZero    = (lenQ == '0);
  assign lastAddr   = ADDR_W'(lenQ - LEN_W'(1));

  always_ff @(posedge clkInt or negedge rstN) begin
    if (!rstN) begin
      lenQ <= '0;
      ptrQ <= '0;
    end else if (clkEn) begin
      if (lenLoad) begin
        lenQ <= lenClamped;
        ptrQ <= '0;
      end else if (!lenZero) begin
        ptrQ <= (ptrQ == lastAddr) ? '0 : ptrQ + ADDR_W'(1);
      end
    end
  end

  always_comb begin
    ctl.advance  = clkEn;
    ctl.ramWrite = clkEn && !lenLoad && !lenZero;
    ctl.bypass   = lenZero;
    ctl.recirc   = recircMode;
  end

  assign ramAddr = ptrQ;
endmodule

// File: rtl/pdl_datapath.sv
module pdl_datapath
  import pdl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int MAX_PROG = 1279,
  parameter int ADDR_W   = 11
) (
  input  logic              clkInt,
  input  logic              rstN,
  input  pdlCtl_t           ctl,
  input  logic [ADDR_W-1:0] ramAddr,
  input  logic [DATA_W-1:0] din,
  input  logic              outEn,
  output logic [DATA_W-1:0] dout,
  output logic              doutDriven,
  output logic [DATA_W-1:0] heldWord
);
  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] ramRd;
  logic [DATA_W-1:0] mem [MAX_PROG];

  assign ramRd = mem[ramAddr];

  always_ff @(posedge clkInt) begin
    if (ctl.ramWrite) mem[ramAddr] <= inReg;
  end

  always_ff @(posedge clkInt or negedge rstN) begin
    if (!rstN) begin
      inReg  <= '0;
      outReg <= '0;
    end else if (ctl.advance) begin
      inReg  <= ctl.recirc ? outReg : din;
      outReg <= ctl.bypass ? inReg : ramRd;
    end
  end

  assign heldWord   = outReg;
  assign dout       = outEn ? outReg : '0;
  assign doutDriven = outEn;
endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import pdl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int LEN_W    = 11,
  parameter int MAX_PROG = 1279
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fallEdge,
  input  logic              clkEn,
  input  logic              lenLoad,
  input  logic [LEN_W-1:0]  lenIn,
  input  logic              recircMode,
  input  logic [DATA_W-1:0] din,
  input  logic              outEn,
  output logic [DATA_W-1:0] dout,
  output logic              doutDriven
);
  localparam int ADDR_W = (MAX_PROG > 1) ? $clog2(MAX_PROG) : 1;

  logic              clkInt;
  pdlCtl_t           ctl;
  logic [ADDR_W-1:0] ramAddr;
  logic [LEN_W-1:0]  lenQ;
  logic [DATA_W-1:0] heldWord;

  // Inverting the clock makes the falling edge the active one.
  assign clkInt = clk ^ fallEdge;

  pdl_ctrl #(.LEN_W(LEN_W), .MAX_PROG(MAX_PROG), .ADDR_W(ADDR_W)) i_ctrl (
    .clkInt(clkInt), .rstN(rstN), .clkEn(clkEn), .lenLoad(lenLoad),
    .lenIn(lenIn), .recircMode(recircMode), .ctl(ctl), .ramAddr(ramAddr),
    .lenQ(lenQ)
  );

  pdl_datapath #(.DATA_W(DATA_W), .MAX_PROG(MAX_PROG), .ADDR_W(ADDR_W)) i_dp (
    .clkInt(clkInt), .rstN(rstN), .ctl(ctl), .ramAddr(ramAddr), .din(din),
    .outEn(outEn), .dout(dout), .doutDriven(doutDriven), .heldWord(heldWord)
  );
endmodule

// File: rtl/pdl_checker.sv
module pdl_checker #(
  parameter int DATA_W   = 10,
  parameter int LEN_W    = 11,
  parameter int MAX_PROG = 1279,
  parameter int ADDR_W   = 11
) (
  input logic              clkInt,
  input logic              rstN,
  input logic              clkEn,
  input logic              lenLoad,
  input logic [LEN_W-1:0]  lenIn,
  input logic              recircMode,
  input logic [DATA_W-1:0] din,
  input logic              outEn,
  input logic [DATA_W-1:0] dout,
  input logic              doutDriven,
  input logic [DATA_W-1:0] heldWord,
  input logic [LEN_W-1:0]  lenQ,
  input logic [ADDR_W-1:0] ptrQ
);
  logic [1:0] warm;
  always_ff @(posedge clkInt or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3
  bypass_latency_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    (warm == 2'd3 && $past(lenQ) == '0 && $past(clkEn) && $past(clkEn, 2)
     && !$past(recircMode, 2)) |-> heldWord == $past(din, 2));

  // R4
  load_ptr_reset_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    (clkEn && lenLoad && lenIn <= LEN_W'(MAX_PROG)) |=> (ptrQ == '0 && lenQ == $past(lenIn)));

  // R5
  len_clamp_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    (clkEn && lenLoad && lenIn > LEN_W'(MAX_PROG)) |=> lenQ == LEN_W'(MAX_PROG));

  // R2
  ptr_range_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    lenQ != '0 |-> LEN_W'(ptrQ) < lenQ);

  // R7
  hold_state_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    !clkEn |=> ($stable(heldWord) && $stable(lenQ) && $stable(ptrQ)));

  // R9
  out_enable_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    outEn |-> (doutDriven && dout == heldWord));

  // R9
  out_disable_chk: assert property (@(posedge clkInt) disable iff (!rstN)
    !outEn |-> (!doutDriven && dout == '0));
endmodule

bind prog_delay_line pdl_checker #(
  .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_PROG(MAX_PROG), .ADDR_W(ADDR_W)
) i_chk (
  .clkInt(clkInt), .rstN(rstN), .clkEn(clkEn), .lenLoad(lenLoad), .lenIn(lenIn),
  .recircMode(recircMode), .din(din), .outEn(outEn), .dout(dout),
  .doutDriven(doutDriven), .heldWord(heldWord), .lenQ(lenQ), .ptrQ(ramAddr)
);

// File: tb/test_prog_delay_line.sv
module test_prog_delay_line;
  localparam int DW = 10;
  localparam int LW = 11;
  localparam int MAXP = 1279;
  localparam int HMASK = 2047;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fallEdge = 1'b0;
  logic clkEn = 1'b1;
  logic lenLoad = 1'b0;
  logic recircMode = 1'b0;
  logic outEn = 1'b1;
  logic [LW-1:0] lenIn = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic doutDriven;

  always #4 clk = ~clk;  // 125 MHz

  prog_delay_line i_prog_delay_line (
    .clk(clk), .rstN(rstN), .fallEdge(fallEdge), .clkEn(clkEn),
    .lenLoad(lenLoad), .lenIn(lenIn), .recircMode(recircMode), .din(din),
    .outEn(outEn), .dout(dout), .doutDriven(doutDriven)
  );

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  int loadIdx = 0;
  int curLen = 0;
  logic [DW-1:0] seed = 10'd17;
  logic [DW-1:0] hist [2048];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nextPat();
    seed = seed * 10'd5 + 10'd3;
    return seed;
  endfunction

  task automatic waitEdge();
    if (fallEdge) @(negedge clk);
    else @(posedge clk);
    #2;
  endtask

  // Records what the input register takes at the coming edge, then waits past it.
  task automatic step(input logic [DW-1:0] nextDin);
    if (clkEn) begin
      hist[edgeCnt & HMASK] = recircMode ? dout : din;
      if (lenLoad) begin
        loadIdx = edgeCnt;
        curLen = (int'(lenIn) > MAXP) ? MAXP : int'(lenIn);
      end
      edgeCnt++;
    end
    waitEdge();
    din = nextDin;
  endtask

  task automatic checkOut(input string tag);
    if (edgeCnt >= loadIdx + curLen + 2)
      chk(dout === hist[(edgeCnt - curLen - 2) & HMASK], tag,
          int'(dout), int'(hist[(edgeCnt - curLen - 2) & HMASK]));
  endtask

  task automatic doReset(input logic fe);
    rstN = 1'b0; lenLoad = 1'b0; clkEn = 1'b1; recircMode = 1'b0; outEn = 1'b1;
    #4 fallEdge = fe;
    #8 rstN = 1'b1;
    edgeCnt = 0; loadIdx = 0; curLen = 0;
    chk(dout === '0, "R1 dout", int'(dout), 0);
    chk(doutDriven === 1'b1, "R1 doutDriven", int'(doutDriven), 1);
  endtask

  task automatic runLen(input int n, input int extra, input string tag);
    int eff;
    eff = (n > MAXP) ? MAXP : n;
    lenIn = LW'(n);
    lenLoad = 1'b1;
    step(nextPat());
    lenLoad = 1'b0;
    repeat (eff + 2 + extra) begin
      step(nextPat());
      checkOut(tag);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold;
    logic [DW-1:0] rec [32];
    #2;
    doReset(1'b0);
    // R3 from reset state (length 0)
    repeat (6) begin step(nextPat()); checkOut("R3"); end

    for (int n = 0; n <= 24; n++) runLen(n, 6, (n == 0) ? "R3" : "R2");
    runLen(100, 4, "R4");
    runLen(7, 4, "R4");
    runLen(MAXP, 4, "R2");
    runLen(2047, 4, "R5");

    // R7: clock enable low freezes everything, load ignored
    runLen(5, 8, "R7");
    hold = dout;
    clkEn = 1'b0;
    lenIn = LW'(2);
    lenLoad = 1'b1;
    repeat (6) begin
      step(nextPat());
      chk(dout === hold, "R7 hold", int'(dout), int'(hold));
    end
    lenLoad = 1'b0;
    clkEn = 1'b1;
    repeat (10) begin step(nextPat()); checkOut("R7"); end

    // R9: output enable
    outEn = 1'b0;
    repeat (4) begin
      step(nextPat());
      chk(dout === '0, "R9 dout", int'(dout), 0);
      chk(doutDriven === 1'b0, "R9 doutDriven", int'(doutDriven), 0);
    end
    outEn = 1'b1;
    #0;
    repeat (4) begin checkOut("R9"); step(nextPat()); end

    // R6: recirculate with N = 3, period 5
    runLen(3, 6, "R6");
    recircMode = 1'b1;
    for (int j = 0; j < 20; j++) begin
      step(nextPat());
      checkOut("R6");
      rec[j] = dout;
      if (j >= 5) chk(rec[j] === rec[j-5], "R6 period", int'(rec[j]), int'(rec[j-5]));
    end
    recircMode = 1'b0;

    // R8: falling edge active
    doReset(1'b1);
    runLen(0, 6, "R8");
    runLen(4, 6, "R8");
    repeat (4) begin
      hold = dout;
      din = nextPat();
      @(posedge clk);
      #2;
      chk(dout === hold, "R8 rising edge inactive", int'(dout), int'(hold));
      step(nextPat());
      checkOut("R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule